// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the serial-side front end of a small byte-organised nonvolatile memory. It acts as a slave on a four-wire serial peripheral bus and works in clock mode 0 or mode 3. All fields travel most significant bit first. Input bits are taken on the rising serial clock edge, and the data output changes only after a falling edge. The front end shifts in an instruction byte and, where one is needed, an address byte. It decodes six commands. For a read it streams array or status bytes out. For the other commands it passes write data and one-cycle strobes to the page buffer and the write-protection logic that sit beside it.

The front end does not run on the serial clock. The serial clock, data input, select and pause inputs are each brought into a faster system clock through a synchronizer chain, and serial clock edges are found on the synchronised copy. The ninth address bit travels inside the instruction byte, so one address byte is enough to reach a 512-byte array. A pause input can freeze a transfer at any bit and later let it continue with nothing lost.

Top module: `spi_mem_frontend`

## Requirements
- R1: An instruction byte whose upper four bits are 0000 and lower three bits are 011 selects a read, and 010 selects a write. Bit 3 of that byte is address bit 8. The next byte gives address bits 7..0. The target address is {bit 3, second byte}, and it appears on `mem_addr_o`.
- R2: Instruction 0000x110 raises `wren_o` and instruction 0000x100 raises `wrdi_o`, each for one system cycle after the eighth bit, whatever the value of bit 3. Never more than one of `wren_o`, `wrdi_o`, `sr_wr_o`, `wr_vld_o` is high in a cycle.
- R3: Instruction 0000x101 shifts `status_i` out MSB first and repeats the status byte for as long as clocks continue.
- R4: Instruction 0000x001 hands the next complete byte to `wr_data_o` with a one-cycle `sr_wr_o`. Any later bits in the same selection are ignored.
- R5: After a write instruction and its address, each complete data byte appears on `wr_data_o` with a one-cycle `wr_vld_o`. `mem_addr_o` keeps the start address.
- R6: A read drives the byte at the address MSB first. The pointer steps by one after each byte and wraps from 2^ADDR_W-1 to 0.
- R7: While select is high, `so_oe_o` is low. A rising select ends any command: a byte that is only partly shifted is dropped, and `op_end_o` pulses once.
- R8: Pause low while the serial clock is low stops the transfer. `so_oe_o` goes low and clock edges are ignored. When pause is released with the clock low, the transfer continues from the bit where it stopped.
- R9: A pause applied while the serial clock is high does not take effect until the clock next falls. That falling edge is still processed.
- R10: An instruction byte with a nonzero upper nibble, or with lower bits 000 or 111, produces no strobe and no output drive until select next rises.
- R11: In mode 3, where the clock idles high at select, the leading falling edge is ignored and commands decode the same way as in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Select, active low |
| hold_n_i | input | 1 | Pause, active low |
| so_o | output | 1 | Serial data out, 0 when not driven |
| so_oe_o | output | 1 | Output enable for the data out pad |
| mem_addr_o | output | ADDR_W | Read pointer, or write start address |
| mem_rd_data_i | input | 8 | Array byte at `mem_addr_o` |
| status_i | input | 8 | Status byte for status reads |
| wr_data_o | output | 8 | Last received write or status byte |
| wr_vld_o | output | 1 | Array write byte strobe |
| sr_wr_o | output | 1 | Status write byte strobe |
| wren_o | output | 1 | Write enable command strobe |
| wrdi_o | output | 1 | Write disable command strobe |
| op_end_o | output | 1 | Select rising strobe |

## Verification
The bench uses the defaults, ADDR_W = 9 and SYNC_STAGES = 2. With nine address bits, the bit carried in the instruction byte is part of every address, and a read started near 0x1FF crosses the wrap to 0 inside one selection. With two synchronizer stages, the serial half period the bench uses leaves a margin of several system cycles between an edge being detected and the next bit being sampled. A short read therefore checks both the address path and the wrap.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;

    localparam int BYTE_W = 8;

    // Transfer phase inside one selection
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_STAT,
        PH_SRWR,
        PH_SKIP
    } phase_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_WREN,
        OP_WRDI,
        OP_RDSR,
        OP_WRSR
    } op_t;

    // Gated serial clock edges as seen by the sequencer
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    // Low three bits select the command; the upper nibble must be clear
    function automatic op_t decode_op(input logic [BYTE_W-1:0] b);
        op_t r;
        r = OP_NONE;
        if (b[7:4] == 4'b0000) begin
            unique case (b[2:0])
                3'b011:  r = OP_READ;
                3'b010:  r = OP_WRITE;
                3'b110:  r = OP_WREN;
                3'b100:  r = OP_WRDI;
                3'b101:  r = OP_RDSR;
                3'b001:  r = OP_WRSR;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [8:0] join_addr(input logic hi, input logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_hold_gate.sv
`timescale 1ns/1ps
module spi_hold_gate
    import spi_mem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_s,
    input  logic      cs_s,
    input  logic      hold_n_s,
    output sck_edge_t edg,
    output logic      held
);

    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_s;
        end
    end

    // Pause state follows the pin only while the clock is low
    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            held <= 1'b0;
        end else if (!sck_s) begin
            held <= !hold_n_s;
        end
    end

    assign edg.rise = sck_s & ~sck_q & ~held & ~cs_s;
    assign edg.fall = ~sck_s & sck_q & ~held & ~cs_s;

    // R9
    hold_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cs_s) && (held != $past(held))) |-> !$past(sck_s));

endmodule

// File: rtl/spi_cmd_fsm.sv
`timescale 1ns/1ps
module spi_cmd_fsm
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              si_s,
    input  sck_edge_t         edg,
    input  logic              held,
    input  logic [BYTE_W-1:0] mem_rd_data,
    input  logic [BYTE_W-1:0] status,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_vld,
    output logic              sr_wr,
    output logic              wren,
    output logic              wrdi,
    output logic              op_end
);

    localparam int CNT_W = $clog2(BYTE_W);

    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shin;
    logic [BYTE_W-1:0] obyte;
    logic              so_q;
    logic              out_live;
    logic              a8;
    logic              rd_mode;
    logic              cs_q;

    logic [BYTE_W-1:0] byte_in;
    logic              byte_done;
    logic [8:0]        addr9;
    logic [ADDR_W-1:0] addr_load;
    logic [BYTE_W-1:0] out_src;
    logic              drive_ph;

    assign byte_in   = {shin, si_s};
    assign byte_done = edg.rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign addr9     = join_addr(a8, byte_in);

    // The ninth address bit only exists for a 512-byte array
    if (ADDR_W == 9) begin : g_hi_bit
        assign addr_load = addr9;
    end else begin : g_lo_only
        assign addr_load = byte_in[ADDR_W-1:0];
    end

    assign out_src  = (phase == PH_RDATA) ? mem_rd_data : status;
    assign drive_ph = (phase == PH_RDATA) || (phase == PH_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shin     <= '0;
            obyte    <= '0;
            so_q     <= 1'b0;
            out_live <= 1'b0;
            a8       <= 1'b0;
            rd_mode  <= 1'b0;
            cs_q     <= 1'b1;
            addr     <= '0;
            wr_data  <= '0;
            wr_vld   <= 1'b0;
            sr_wr    <= 1'b0;
            wren     <= 1'b0;
            wrdi     <= 1'b0;
            op_end   <= 1'b0;
        end else begin
            wr_vld <= 1'b0;
            sr_wr  <= 1'b0;
            wren   <= 1'b0;
            wrdi   <= 1'b0;
            cs_q   <= cs_s;
            op_end <= cs_s & ~cs_q;
            if (cs_s) begin
                phase    <= PH_IDLE;
                bit_cnt  <= '0;
                out_live <= 1'b0;
            end else if (phase == PH_IDLE) begin
                phase <= PH_CMD;
            end else begin
                if (edg.rise) begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    shin    <= byte_in[BYTE_W-2:0];
                end
                if (byte_done) begin
                    unique case (phase)
                        PH_CMD: begin
                            unique case (decode_op(byte_in))
                                OP_READ: begin
                                    a8      <= byte_in[3];
                                    rd_mode <= 1'b1;
                                    phase   <= PH_ADDR;
                                end
                                OP_WRITE: begin
                                    a8      <= byte_in[3];
                                    rd_mode <= 1'b0;
                                    phase   <= PH_ADDR;
                                end
                                OP_WREN: begin
                                    wren  <= 1'b1;
                                    phase <= PH_SKIP;
                                end
                                OP_WRDI: begin
                                    wrdi  <= 1'b1;
                                    phase <= PH_SKIP;
                                end
                                OP_RDSR: phase <= PH_STAT;
                                OP_WRSR: phase <= PH_SRWR;
                                default: phase <= PH_SKIP;
                            endcase
                        end
                        PH_ADDR: begin
                            addr  <= addr_load;
                            phase <= rd_mode ? PH_RDATA : PH_WDATA;
                        end
                        PH_RDATA: addr <= addr + ADDR_W'(1);
                        PH_WDATA: begin
                            wr_data <= byte_in;
                            wr_vld  <= 1'b1;
                        end
                        PH_SRWR: begin
                            wr_data <= byte_in;
                            sr_wr   <= 1'b1;
                            phase   <= PH_SKIP;
                        end
                        default: ;
                    endcase
                end
                if (edg.fall && drive_ph) begin
                    out_live <= 1'b1;
                    if (bit_cnt == '0) begin
                        so_q  <= out_src[BYTE_W-1];
                        obyte <= {out_src[BYTE_W-2:0], 1'b0};
                    end else begin
                        so_q  <= obyte[BYTE_W-1];
                        obyte <= {obyte[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign so_oe = drive_ph && out_live && !held && !cs_s;
    assign so    = so_oe ? so_q : 1'b0;

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(held) && !$past(cs_s) && ($past(phase) != PH_IDLE)) |-> (bit_cnt == $past(bit_cnt)));

    // R7
    desel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> ((phase == PH_IDLE) && (bit_cnt == '0)));

    // R6
    rd_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(phase) == PH_RDATA) && $past(edg.rise) && ($past(bit_cnt) == CNT_W'(BYTE_W - 1))
         && !$past(cs_s)) |-> (addr == ADDR_W'($past(addr) + ADDR_W'(1))));

    // R5
    wr_vld_src_chk: assert property (@(posedge clk) disable iff (rst)
        wr_vld |-> ($past(phase) == PH_WDATA));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wren, wrdi, sr_wr, wr_vld}));

endmodule

// File: rtl/spi_mem_frontend.sv
`timescale 1ns/1ps
module spi_mem_frontend
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              cs_n_i,
    input  logic              hold_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rd_data_i,
    input  logic [7:0]        status_i,
    output logic [7:0]        wr_data_o,
    output logic              wr_vld_o,
    output logic              sr_wr_o,
    output logic              wren_o,
    output logic              wrdi_o,
    output logic              op_end_o
);

    localparam int PIN_W = 4;

    logic [PIN_W-1:0] pins_s;
    logic             sck_s;
    logic             si_s;
    logic             cs_s;
    logic             hold_n_s;
    sck_edge_t        edg;
    logic             held;

    spi_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({hold_n_i, cs_n_i, si_i, sck_i}),
        .q   (pins_s)
    );

    assign {hold_n_s, cs_s, si_s, sck_s} = pins_s;

    spi_hold_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .cs_s     (cs_s),
        .hold_n_s (hold_n_s),
        .edg      (edg),
        .held     (held)
    );

    spi_cmd_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cs_s        (cs_s),
        .si_s        (si_s),
        .edg         (edg),
        .held        (held),
        .mem_rd_data (mem_rd_data_i),
        .status      (status_i),
        .so          (so_o),
        .so_oe       (so_oe_o),
        .addr        (mem_addr_o),
        .wr_data     (wr_data_o),
        .wr_vld      (wr_vld_o),
        .sr_wr       (sr_wr_o),
        .wren        (wren_o),
        .wrdi        (wrdi_o),
        .op_end      (op_end_o)
    );

endmodule

// File: tb/spi_mem_frontend_bench.sv
`timescale 1ns/1ps
module spi_mem_frontend_bench;

    localparam int AW = 9;
    localparam int H  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic cs_n = 1'b1;
    logic hold_n = 1'b1;
    logic so, so_oe, wr_vld, sr_wr, wren, wrdi, op_end;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rd_data, status, wr_data;

    logic [7:0] mem [512];
    logic [7:0] wr_log [32];

    int n_checks = 0;
    int n_fail = 0;
    int n_wren = 0, n_wrdi = 0, n_sr = 0, n_wr = 0, n_oe = 0, n_end = 0;
    logic [7:0] sr_last = 8'h00;

    always #2 clk = ~clk;

    assign mem_rd_data = mem[mem_addr];

    spi_mem_frontend u_spi_mem_frontend (
        .clk           (clk),
        .rst           (rst),
        .sck_i         (sck),
        .si_i          (si),
        .cs_n_i        (cs_n),
        .hold_n_i      (hold_n),
        .so_o          (so),
        .so_oe_o       (so_oe),
        .mem_addr_o    (mem_addr),
        .mem_rd_data_i (mem_rd_data),
        .status_i      (status),
        .wr_data_o     (wr_data),
        .wr_vld_o      (wr_vld),
        .sr_wr_o       (sr_wr),
        .wren_o        (wren),
        .wrdi_o        (wrdi),
        .op_end_o      (op_end)
    );

    always @(negedge clk) begin
        if (wren) n_wren++;
        if (wrdi) n_wrdi++;
        if (sr_wr) begin n_sr++; sr_last = wr_data; end
        if (wr_vld) begin wr_log[n_wr % 32] = wr_data; n_wr++; end
        if (so_oe) n_oe++;
        if (op_end) n_end++;
    end

    function automatic logic [7:0] op_byte(input logic [2:0] code, input logic bit3);
        return {4'b0000, bit3, code};
    endfunction

    function automatic logic [7:0] exp_rd(input int a, input int k);
        return mem[(a + k) % 512];
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic tx, output logic rx);
        si = tx;
        wait_clk(H);
        rx = so;
        sck = 1'b1;
        wait_clk(H);
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic desel();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic do_read(input int a, input int n, input string req);
        logic [7:0] rx;
        sel();
        xbyte(op_byte(3'b011, a[8]), rx);
        xbyte(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx);
            chk(rx == exp_rd(a, k), req, "read byte", rx, exp_rd(a, k));
        end
        desel();
    endtask

    task automatic do_write(input int a, input int n, input string req);
        logic [7:0] rx;
        logic [7:0] d [4];
        int base;
        base = n_wr;
        sel();
        xbyte(op_byte(3'b010, a[8]), rx);
        xbyte(a[7:0], rx);
        for (int k = 0; k < n; k++) begin
            d[k] = 8'($urandom);
            xbyte(d[k], rx);
        end
        desel();
        chk(n_wr - base == n, req, "write byte count", n_wr - base, n);
        for (int k = 0; k < n; k++) begin
            chk(wr_log[(base + k) % 32] == d[k], req, "write byte value", wr_log[(base + k) % 32], d[k]);
        end
        chk(mem_addr == a[AW-1:0], "R1", "write start address", mem_addr, a);
    endtask

    initial begin
        logic [7:0] rx;
        logic b;
        int c0, c1, e0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        status = 8'hA5;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        chk(so_oe == 1'b0, "R7", "reset output enable", so_oe, 0);
        chk(mem_addr == '0, "R6", "reset pointer", mem_addr, 0);
        chk({wren, wrdi, sr_wr, wr_vld} == 4'b0, "R2", "reset strobes", {wren, wrdi, sr_wr, wr_vld}, 0);

        // R2: enable with bit 3 set, disable with bit 3 clear
        c0 = n_wren; e0 = n_end;
        sel(); xbyte(op_byte(3'b110, 1'b1), rx); desel();
        chk(n_wren - c0 == 1, "R2", "wren strobe", n_wren - c0, 1);
        chk(n_end - e0 == 1, "R7", "end strobe", n_end - e0, 1);
        c0 = n_wrdi;
        sel(); xbyte(op_byte(3'b100, 1'b0), rx); desel();
        chk(n_wrdi - c0 == 1, "R2", "wrdi strobe", n_wrdi - c0, 1);

        // R3: status read repeats
        sel(); xbyte(op_byte(3'b101, 1'b0), rx);
        xbyte(8'h00, rx); chk(rx == 8'hA5, "R3", "status byte 0", rx, 8'hA5);
        xbyte(8'h00, rx); chk(rx == 8'hA5, "R3", "status byte 1", rx, 8'hA5);
        desel();
        chk(so_oe == 1'b0, "R7", "deselected enable", so_oe, 0);

        // R4: status write, later byte ignored
        c0 = n_sr;
        sel(); xbyte(op_byte(3'b001, 1'b1), rx); xbyte(8'h8C, rx); xbyte(8'h33, rx); desel();
        chk(n_sr - c0 == 1, "R4", "status write count", n_sr - c0, 1);
        chk(sr_last == 8'h8C, "R4", "status write value", sr_last, 8'h8C);

        // R5 / R1: write with address bit 8 set
        do_write(9'h1F3, 3, "R5");
        do_write(9'h004, 1, "R5");

        // R6 / R1: directed reads, including the wrap
        do_read(9'h123, 3, "R1");
        do_read(9'h1FE, 4, "R6");

        // R7: write aborted mid byte
        c0 = n_wr;
        sel(); xbyte(op_byte(3'b010, 1'b0), rx); xbyte(8'h40, rx);
        for (int i = 0; i < 4; i++) xbit(1'b1, b);
        desel();
        chk(n_wr == c0, "R7", "partial byte dropped", n_wr - c0, 0);

        // R10: unrecognised opcodes
        c0 = n_wren + n_wrdi + n_sr + n_wr; c1 = n_oe;
        sel(); xbyte(8'h13, rx); xbyte(8'h00, rx); xbyte(8'h00, rx); desel();
        sel(); xbyte(8'h07, rx); xbyte(8'h00, rx); xbyte(8'h00, rx); desel();
        chk(n_wren + n_wrdi + n_sr + n_wr == c0, "R10", "no strobe", n_wren + n_wrdi + n_sr + n_wr - c0, 0);
        chk(n_oe == c1, "R10", "no drive", n_oe - c1, 0);
        c0 = n_wren;
        sel(); xbyte(op_byte(3'b110, 1'b0), rx); desel();
        chk(n_wren - c0 == 1, "R10", "next command decodes", n_wren - c0, 1);

        // R8: pause with clock low mid byte
        sel(); xbyte(op_byte(3'b011, 1'b0), rx); xbyte(8'h55, rx);
        for (int i = 7; i >= 4; i--) begin xbit(1'b0, b); rx[i] = b; end
        hold_n = 1'b0; wait_clk(H);
        chk(so_oe == 1'b0, "R8", "paused enable", so_oe, 0);
        for (int i = 0; i < 3; i++) begin sck = 1'b1; si = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H); end
        hold_n = 1'b1; wait_clk(H);
        for (int i = 3; i >= 0; i--) begin xbit(1'b0, b); rx[i] = b; end
        chk(rx == exp_rd(9'h055, 0), "R8", "resumed byte", rx, exp_rd(9'h055, 0));
        xbyte(8'h00, rx);
        chk(rx == exp_rd(9'h055, 1), "R8", "byte after pause", rx, exp_rd(9'h055, 1));
        desel();

        // R9: pause with clock high waits for the falling edge
        sel(); xbyte(op_byte(3'b011, 1'b1), rx); xbyte(8'h80, rx);
        for (int i = 7; i >= 6; i--) begin xbit(1'b0, b); rx[i] = b; end
        si = 1'b0; wait_clk(H); rx[5] = so; sck = 1'b1; wait_clk(H);
        hold_n = 1'b0; wait_clk(H);
        chk(so_oe == 1'b1, "R9", "enable before fall", so_oe, 1);
        sck = 1'b0; wait_clk(H);
        chk(so_oe == 1'b0, "R9", "enable after fall", so_oe, 0);
        hold_n = 1'b1; wait_clk(H);
        for (int i = 4; i >= 0; i--) begin xbit(1'b0, b); rx[i] = b; end
        chk(rx == exp_rd(9'h180, 0), "R9", "byte across pause", rx, exp_rd(9'h180, 0));
        desel();

        // R11: mode 3 status read
        sck = 1'b1; wait_clk(H);
        cs_n = 1'b0; wait_clk(H);
        sck = 1'b0; wait_clk(H);
        xbyte(op_byte(3'b101, 1'b1), rx); xbyte(8'h00, rx);
        chk(rx == 8'hA5, "R11", "mode 3 status", rx, 8'hA5);
        sck = 1'b1; wait_clk(H); cs_n = 1'b1; wait_clk(2 * H); sck = 1'b0; wait_clk(2 * H);

        // Random mix of reads and writes
        for (int t = 0; t < 24; t++) begin
            int a, n;
            a = int'($urandom % 512);
            n = 1 + int'($urandom % 4);
            if ($urandom % 2 == 0) do_read(a, n, "R6");
            else do_write(a, n, "R5");
        end

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule